// File: doc/BRIEF.md
# Priority Interrupt Controller with Level Threshold

This block watches a bank of request lines from peripherals, one line for each device. Every line has a fixed rank given by its position, and the highest index ranks highest. Of the lines that are both enabled and active, the block selects the top-ranked one. That line's index is the identifying code the processor uses to find the right service routine.

A single interrupt line to the processor is registered. It rises only when the selected request is at or above a programmable minimum level, so less urgent devices can be held off without clearing their enables.

When the processor acknowledges, the code is captured into a held register, so a read in progress is not disturbed by later request changes. Software configures the block through a small write port that selects either the per-line enable mask or the level.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_o` is 0, `code_o` is 0, `code_vld_o` is 0, every enable is clear and the level is 0.
- R2: The selected code is the index of the highest-index line that is both enabled and active. A lower index is chosen only when no higher enabled line is active.
- R3: A line whose enable bit is 0 takes no part in selection and cannot cause `irq_o`.
- R4: `irq_o` rises on the first clock edge at which an enabled active request exists whose selected code is greater than or equal to the level.
- R5: While the selected code is below the level, `irq_o` stays 0, even though a code is still selected and can be captured.
- R6: `irq_o` falls on the first clock edge at which no qualifying request remains.
- R7: On a clock edge with `ack_i` high, `code_o` takes the selected code and `code_vld_o` shows whether any enabled line was active. With `ack_i` low, both hold their values.
- R8: On a clock edge with `cfg_we_i` high, `cfg_sel_i` = 0 loads the enable mask from `cfg_wdata_i` (bit i enables line i), and `cfg_sel_i` = 1 loads the level from the low `CODE_W` bits of `cfg_wdata_i`. With `cfg_we_i` low, the configuration is unchanged.
- R9: An acknowledge with no enabled active line gives `code_o` = 0 and `code_vld_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | NUM_SRC | Request lines, index = rank |
| ack_i | input | 1 | Processor acknowledge; captures the code |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | 0 = enable mask, 1 = level |
| cfg_wdata_i | input | NUM_SRC | Configuration write data |
| irq_o | output | 1 | Registered interrupt to the processor |
| code_o | output | CODE_W | Held code of the selected line |
| code_vld_o | output | 1 | Held flag: an enabled line was active at capture |

## Verification
The selection is driven with a single low line, a single top line, several lines at once, and patterns where the highest active line is masked off. Together these separate true rank order from a lowest-first or unmasked encoder. The level is set below, equal to and above the selected code, which shows whether the comparison is inclusive and whether it uses the winner rather than any active line. Directed cases measure the rise and fall of `irq_o` on the exact edge. They also change requests after a capture without acknowledging, to show that the held code does not move.

// File: rtl/prio_irq_pkg.sv
// Package: shared configuration-select encoding for the interrupt controller.
// Assumes: one select bit is enough to address the two configuration registers.
package prio_irq_pkg;
    typedef enum logic {
        CFG_MASK  = 1'b0,
        CFG_LEVEL = 1'b1
    } cfg_sel_e;
endpackage

// File: rtl/prio_irq_cfg.sv
// Module: configuration registers (enable mask and minimum level).
// Assumes: CODE_W <= NUM_SRC, so the level fits in the write data.
module prio_irq_cfg
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int CODE_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  cfg_sel_e           sel_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    output logic [NUM_SRC-1:0] en_o,
    output logic [CODE_W-1:0]  level_o
);
    // Register updates on a write strobe; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o    <= '0;
            level_o <= '0;
        end else if (we_i) begin
            if (sel_i == CFG_MASK) en_o    <= wdata_i;
            else                   level_o <= wdata_i[CODE_W-1:0];
        end
    end

    // Without a write strobe, the configuration must not move.
    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> ($stable(en_o) && $stable(level_o)));
endmodule

// File: rtl/prio_irq_enc.sv
// Module: masked fixed-priority encoder; the highest enabled active index wins.
// Assumes: the winning index is itself the device code.
module prio_irq_enc #(
    parameter int NUM_SRC = 8,
    parameter int CODE_W  = 3
) (
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [NUM_SRC-1:0] en_i,
    output logic [CODE_W-1:0]  win_o,
    output logic               any_o
);
    logic [NUM_SRC-1:0] live;

    // One gate per line removes disabled lines from the contest.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_mask
        assign live[g] = req_i[g] & en_i[g];
    end

    // Scan upward so that the last active index, the highest, is kept.
    always_comb begin
        win_o = '0;
        any_o = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (live[i]) begin
                win_o = CODE_W'(i);
                any_o = 1'b1;
            end
        end
    end

    // The winner is live and nothing above it is live.
    always_comb begin
        if (any_o) begin
            p_win_top_r2: assert ((live >> win_o) == NUM_SRC'(1));
        end
        if (!any_o) begin
            p_none_live_r3: assert (live == '0);
        end
    end
endmodule

// File: rtl/prio_irq_hold.sv
// Module: code holding register, loaded only on a processor acknowledge.
// Assumes: ack_i is synchronous to clk.
module prio_irq_hold #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_i,
    input  logic [CODE_W-1:0] win_i,
    input  logic              any_i,
    output logic [CODE_W-1:0] code_o,
    output logic              vld_o
);
    // Capture the current winner on acknowledge; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o <= '0;
            vld_o  <= 1'b0;
        end else if (ack_i) begin
            code_o <= any_i ? win_i : '0;
            vld_o  <= any_i;
        end
    end

    // A read in progress is never disturbed without an acknowledge.
    p_code_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |=> ($stable(code_o) && $stable(vld_o)));
    // With no live line captured, the code reads as zero.
    p_empty_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_o |-> (code_o == '0));
endmodule

// File: rtl/prio_irq_ctrl.sv
// Module: top of the priority interrupt controller with a level threshold.
// Assumes: all inputs are synchronous to clk; reset is synchronous, active low.
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int CODE_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic               ack_i,
    input  logic               cfg_we_i,
    input  logic               cfg_sel_i,
    input  logic [NUM_SRC-1:0] cfg_wdata_i,
    output logic               irq_o,
    output logic [CODE_W-1:0]  code_o,
    output logic               code_vld_o
);
    logic [NUM_SRC-1:0] en;
    logic [CODE_W-1:0]  level;
    logic [CODE_W-1:0]  win;
    logic               any;
    logic               irq_q;

    prio_irq_cfg #(.NUM_SRC(NUM_SRC), .CODE_W(CODE_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we_i),
        .sel_i   (cfg_sel_e'(cfg_sel_i)),
        .wdata_i (cfg_wdata_i),
        .en_o    (en),
        .level_o (level)
    );

    prio_irq_enc #(.NUM_SRC(NUM_SRC), .CODE_W(CODE_W)) u_enc (
        .req_i (req_i),
        .en_i  (en),
        .win_o (win),
        .any_o (any)
    );

    prio_irq_hold #(.CODE_W(CODE_W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .ack_i  (ack_i),
        .win_i  (win),
        .any_i  (any),
        .code_o (code_o),
        .vld_o  (code_vld_o)
    );

    // Register the interrupt: a live winner at or above the level raises it.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= any && (win >= level);
    end

    assign irq_o = irq_q;

    // An interrupt always traces back to a winner that met the level.
    p_irq_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(win) >= $past(level)));
    // With no live line one cycle earlier, the interrupt is low.
    p_irq_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!any) |-> !irq_o);
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
    localparam int N  = 8;
    localparam int CW = 3;
    localparam int NV = 12;
    // Fields: mask[23:16] level[15:13] req[12:5] code[4:2] vld[1] irq[0]
    localparam logic [23:0] VEC [0:NV-1] = '{
        {8'hFF, 3'd0, 8'h01, 3'd0, 1'b1, 1'b1},
        {8'hFF, 3'd0, 8'h81, 3'd7, 1'b1, 1'b1},
        {8'hFF, 3'd0, 8'h24, 3'd5, 1'b1, 1'b1},
        {8'h0F, 3'd0, 8'hF0, 3'd0, 1'b0, 1'b0},
        {8'h0F, 3'd0, 8'hF4, 3'd2, 1'b1, 1'b1},
        {8'hFF, 3'd5, 8'h18, 3'd4, 1'b1, 1'b0},
        {8'hFF, 3'd5, 8'h38, 3'd5, 1'b1, 1'b1},
        {8'hFF, 3'd7, 8'h7F, 3'd6, 1'b1, 1'b0},
        {8'hFF, 3'd7, 8'h80, 3'd7, 1'b1, 1'b1},
        {8'h00, 3'd0, 8'hFF, 3'd0, 1'b0, 1'b0},
        {8'hAA, 3'd3, 8'h55, 3'd0, 1'b0, 1'b0},
        {8'hAA, 3'd3, 8'h5A, 3'd3, 1'b1, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic          ack = 1'b0;
    logic          cfg_we = 1'b0;
    logic          cfg_sel = 1'b0;
    logic [N-1:0]  cfg_wdata = '0;
    logic          irq;
    logic [CW-1:0] code;
    logic          code_vld;
    int            n_chk = 0;
    int            n_bad = 0;
    bit            done = 1'b0;

    always #2.5 clk = ~clk;

    prio_irq_ctrl #(.NUM_SRC(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .ack_i(ack),
        .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
        .irq_o(irq), .code_o(code), .code_vld_o(code_vld)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic sel, input logic [N-1:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic acknowledge();
        ack = 1'b1;
        tick();
        ack = 1'b0;
    endtask

    initial begin
        repeat (3) tick();
        // R1: state right after reset
        check("R1 irq", int'(irq), 0);
        check("R1 code", int'(code), 0);
        check("R1 vld", int'(code_vld), 0);
        rst_n = 1'b1;
        req = 8'hFF;
        tick();
        tick();
        check("R1 enables clear, no irq", int'(irq), 0);
        acknowledge();
        check("R1 enables clear, vld", int'(code_vld), 0);

        // Table walk: R2 R3 R5 R8 R9 per vector
        for (int v = 0; v < NV; v++) begin
            cfg_write(1'b0, VEC[v][23:16]);
            cfg_write(1'b1, N'(VEC[v][15:13]));
            req = VEC[v][12:5];
            tick();
            acknowledge();
            check($sformatf("R2/R3 vec%0d code", v), int'(code), int'(VEC[v][4:2]));
            check($sformatf("R9 vec%0d vld", v), int'(code_vld), int'(VEC[v][1]));
            check($sformatf("R5/R8 vec%0d irq", v), int'(irq), int'(VEC[v][0]));
        end

        // R4: rise on the first edge, not before
        req = '0;
        cfg_write(1'b0, 8'hFF);
        cfg_write(1'b1, 8'd2);
        tick();
        check("R6 idle irq", int'(irq), 0);
        req = 8'h08;
        #1;
        check("R4 irq before edge", int'(irq), 0);
        tick();
        check("R4 irq after one edge", int'(irq), 1);

        // R6: fall on the first edge after the request goes
        req = 8'h00;
        #1;
        check("R6 irq before edge", int'(irq), 1);
        tick();
        check("R6 irq after one edge", int'(irq), 0);

        // R7: held code survives request changes without acknowledge
        req = 8'h80;
        tick();
        acknowledge();
        check("R7 captured", int'(code), 7);
        req = 8'h02;
        tick();
        tick();
        check("R7 held code", int'(code), 7);
        check("R7 held vld", int'(code_vld), 1);
        acknowledge();
        check("R7 new capture", int'(code), 1);

        // R8: a write strobe low leaves the mask untouched
        cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = 8'h00;
        req = 8'h40;
        tick();
        tick();
        check("R8 mask unchanged irq", int'(irq), 1);

        // R5: raising the level above the winner drops the interrupt
        cfg_write(1'b1, 8'd7);
        tick();
        check("R5 level above winner", int'(irq), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule